// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory

A clocked static memory for cache-style use. Its word is 36 bits wide, made of four 9-bit byte lanes, and its depth is set by the address width. Address and control are sampled on the rising clock edge. A read returns its data through two registers. A write takes its data one edge after its address.

An access is opened by one of two start strobes: a processor strobe or a controller strobe. The four words that follow are reached by stepping a 2-bit counter held inside the block. Three chip selects support depth expansion. Their timing means that two banks sharing a bus never both present data. An output enable masks the valid flag at once, without waiting for a clock edge. A sleep input freezes the block and keeps its contents.

Data-in and data-out are separate buses, and the output is qualified by a valid flag. The flag stands in for the tri-state drive of a pad.

Top module: `pbsram_core`

## Requirements
- R1: A read whose address is sampled on edge N gives `dout_vld`=1 and `dout` = the stored word after edge N+2, for exactly one cycle. After edge N+1, `dout_vld` is still 0.
- R2: With `wr_all_n`=0 at the address edge, all four lanes are written. This holds whatever `wr_byte_n` and `lane_wr_n` are. Lane i is `din[9i+8:9i]`.
- R3: With `wr_all_n`=1 and `wr_byte_n`=0, only the lanes i with `lane_wr_n[i]`=0 are written, and the other lanes keep their data. With both `wr_all_n` and `wr_byte_n` high, the access is a read and nothing is written.
- R4: A write whose address is sampled on edge N stores the `din` present at edge N+1. A read of the same address sampled on edge N+1 returns that new word.
- R5: While `sel1_n`=1, a low `start_p_n` is ignored. No access starts and the burst counter is not reloaded.
- R6: Either start strobe, with the chip selected, loads the address and clears the counter. Each later edge that has `step_n`=0, no start and an open burst accesses the next word. With `BURST_ILV`=0 (the default), the low two address bits go base+k mod 4. With `BURST_ILV`=1 they go base XOR k. The upper bits are held.
- R7: `out_en_n`=1 forces `dout_vld` low at once, with no clock edge needed.
- R8: The chip is selected when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A start strobe while it is not selected closes the burst and returns no data. The read sampled on the edge before such a deselect is dropped, so the output turns off one cycle after the deselect. A selected read drives the output two cycles after it is sampled.
- R9: While `sleep`=1, `dout_vld` is low at once and all accesses are ignored. Memory contents are kept. The first edge after `sleep` falls accepts an access again.
- R10: After reset, `dout_vld`=0 and no burst is open, so `step_n`=0 produces no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| start_p_n | input | 1 | Processor start strobe, active low, gated by `sel1_n` |
| start_c_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Full-width write, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_vld | output | 1 | Read data valid (drive indication) |

## Verification
Read data is due in the cycle after the second edge following the address edge. Write data is taken on the edge after the address edge. The deselect cut-off shows in the cycle after the edge that follows the deselect. The bench drives inputs on falling edges and counts rising edges from the address edge before it samples. For each read it checks the cycle after edge N+1 (no data yet) and the cycle after edge N+2 (data present). The output enable and the sleep mask are checked a few nanoseconds after the input changes, inside one clock phase, to show that they act without an edge.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int LANES_DEF  = 4;
  localparam int LANE_W_DEF = 9;
  localparam int AW_DEF     = 8;
  localparam int CNT_W      = 2;
endpackage

// File: rtl/pbsram_burst_ctl.sv
module pbsram_burst_ctl
  import pbsram_pkg::*;
#(
  parameter int AW        = AW_DEF,
  parameter int LANES     = LANES_DEF,
  parameter bit BURST_ILV = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             start_p_n,
  input  logic             start_c_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             sleep,
  output logic             s1_vld,
  output logic             s1_rd,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_mask,
  output logic             kill,
  output logic [CNT_W-1:0] cnt_q,
  output logic             act_q
);
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_nxt, low_nxt;
  logic             start, sel_ok, step, go, is_wr;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] mask;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  generate
    if (BURST_ILV) begin : g_ilv
      assign low_nxt = base_q[CNT_W-1:0] ^ cnt_nxt;
    end else begin : g_lin
      assign low_nxt = base_q[CNT_W-1:0] + cnt_nxt;
    end
  endgenerate

  always_comb begin
    sel_ok   = !sel1_n && sel2 && !sel3_n;
    start    = (!start_p_n && !sel1_n) || !start_c_n;
    step     = !start && act_q && !step_n;
    go       = !sleep && ((start && sel_ok) || step);
    kill     = !sleep && start && !sel_ok;
    is_wr    = !wr_all_n || !wr_byte_n;
    acc_addr = start ? addr : {base_q[AW-1:CNT_W], low_nxt};
    if (!wr_all_n)       mask = '1;
    else if (!wr_byte_n) mask = ~lane_wr_n;
    else                 mask = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      s1_vld  <= 1'b0;
      s1_rd   <= 1'b0;
      s1_addr <= '0;
      s1_mask <= '0;
    end else if (sleep) begin
      s1_vld <= 1'b0;
      s1_rd  <= 1'b0;
    end else begin
      s1_vld  <= go;
      s1_rd   <= go && !is_wr;
      s1_addr <= acc_addr;
      s1_mask <= mask;
      if (start) begin
        act_q <= sel_ok;
        if (sel_ok) begin
          base_q <= addr;
          cnt_q  <= '0;
        end
      end else if (step) begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/pbsram_lane_array.sv
module pbsram_lane_array
  import pbsram_pkg::*;
#(
  parameter int AW     = AW_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en) q <= mem[addr];
    end
    assign rdata[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/pbsram_rd_pipe.sv
module pbsram_rd_pipe
  import pbsram_pkg::*;
#(
  parameter int W = LANES_DEF * LANE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         kill,
  input  logic         s1_rd,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] dout_q,
  output logic         dv_q
);
  logic s2_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_rd  <= 1'b0;
      dv_q   <= 1'b0;
      dout_q <= '0;
    end else if (sleep) begin
      s2_rd <= 1'b0;
      dv_q  <= 1'b0;
    end else begin
      s2_rd <= s1_rd && !kill;
      dv_q  <= s2_rd;
      if (s2_rd) dout_q <= rdata;
    end
  end
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter int AW        = AW_DEF,
  parameter int LANES     = LANES_DEF,
  parameter int LANE_W    = LANE_W_DEF,
  parameter bit BURST_ILV = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr,
  input  logic                    start_p_n,
  input  logic                    start_c_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int W = LANES * LANE_W;

  logic             s1_vld, s1_rd, kill, burst_act, dv_q;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_mask;
  logic [CNT_W-1:0] burst_cnt;
  logic [W-1:0]     rdata;

  pbsram_burst_ctl #(.AW(AW), .LANES(LANES), .BURST_ILV(BURST_ILV)) u_ctl (
    .clk(clk), .rst(rst), .addr(addr), .start_p_n(start_p_n),
    .start_c_n(start_c_n), .step_n(step_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n), .sel1_n(sel1_n),
    .sel2(sel2), .sel3_n(sel3_n), .sleep(sleep), .s1_vld(s1_vld),
    .s1_rd(s1_rd), .s1_addr(s1_addr), .s1_mask(s1_mask), .kill(kill),
    .cnt_q(burst_cnt), .act_q(burst_act)
  );

  pbsram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk),
    .wr_en(s1_vld && !s1_rd && !sleep),
    .rd_en(s1_rd && !sleep),
    .addr(s1_addr), .mask(s1_mask), .wdata(din), .rdata(rdata)
  );

  pbsram_rd_pipe #(.W(W)) u_pipe (
    .clk(clk), .rst(rst), .sleep(sleep), .kill(kill), .s1_rd(s1_rd),
    .rdata(rdata), .dout_q(dout), .dv_q(dv_q)
  );

  assign dout_vld = dv_q && !out_en_n && !sleep;
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep,
  input logic          start_p_n,
  input logic          start_c_n,
  input logic          step_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          out_en_n,
  input logic          dout_vld,
  input logic          s1_vld,
  input logic          s1_rd,
  input logic [CW-1:0] burst_cnt,
  input logic          burst_act
);
  logic strobe, chosen;
  assign strobe = (!start_p_n && !sel1_n) || !start_c_n;
  assign chosen = !sel1_n && sel2 && !sel3_n;

  // R1: valid data traces back to a read in stage one two edges earlier
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> $past(s1_rd, 2));

  // R5: gated processor strobe alone starts nothing
  a_r5_ignore: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !start_p_n && sel1_n && start_c_n && step_n) |=> !s1_vld);

  // R6: a step inside an open burst advances the counter by one
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (!sleep && burst_act && !step_n && !strobe) |=>
      burst_cnt == CW'($past(burst_cnt) + CW'(1)));

  // R7: output enable masks the flag
  a_r7_oe: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dout_vld);

  // R8: output off one cycle after a deselecting strobe
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strobe && !chosen) |-> ##2 !dout_vld);

  // R9: sleep masks the output and freezes the counter
  a_r9_mask: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_vld);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(burst_cnt));

  // R10: reset leaves no valid output
  a_r10_reset: assert property (@(posedge clk)
    rst |=> !dout_vld);
endmodule

bind pbsram_core pbsram_chk #(.CW(pbsram_pkg::CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .start_p_n(start_p_n),
  .start_c_n(start_c_n), .step_n(step_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .out_en_n(out_en_n), .dout_vld(dout_vld),
  .s1_vld(s1_vld), .s1_rd(s1_rd), .burst_cnt(burst_cnt),
  .burst_act(burst_act)
);

// File: tb/pbsram_core_test.sv
`timescale 1ns/1ps
module pbsram_core_test;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        start_p_n = 1'b1, start_c_n = 1'b1, step_n = 1'b1;
  logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic        sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic        out_en_n = 1'b0, sleep = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_vld;

  logic [35:0] ref_mem [NW];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pbsram_core uut (
    .clk(clk), .rst(rst), .addr(addr), .start_p_n(start_p_n),
    .start_c_n(start_c_n), .step_n(step_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n), .sel1_n(sel1_n),
    .sel2(sel2), .sel3_n(sel3_n), .out_en_n(out_en_n), .sleep(sleep),
    .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input bit all_n, input bit byte_n,
                                          input logic [3:0] lanes_n);
    if (!all_n) return 4'hF;
    if (!byte_n) return ~lanes_n;
    return 4'h0;
  endfunction

  task automatic idle();
    start_p_n = 1'b1; start_c_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_wr_n = 4'hF;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [35:0] d,
                          input bit all_n, input bit byte_n,
                          input logic [3:0] lanes_n, input bit use_p);
    logic [3:0] m;
    @(negedge clk);
    idle();
    addr = a;
    if (use_p) start_p_n = 1'b0; else start_c_n = 1'b0;
    wr_all_n = all_n; wr_byte_n = byte_n; lane_wr_n = lanes_n;
    @(negedge clk);
    idle();
    din = d;
    @(posedge clk);
    m = exp_mask(all_n, byte_n, lanes_n);
    for (int i = 0; i < 4; i++)
      if (m[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  task automatic do_read(input logic [7:0] a, input bit use_p, input string req);
    @(negedge clk);
    idle();
    addr = a;
    if (use_p) start_p_n = 1'b0; else start_c_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dout_vld === 1'b0, {req, " not yet valid after N+1"}, 36'(dout_vld), 36'd0);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === ref_mem[a], {req, " read data after N+2"},
        dout, ref_mem[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] d, old;
    void'($urandom(32'd424242));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state and no open burst
    chk(dout_vld === 1'b0, "R10 reset output", 36'(dout_vld), 36'd0);
    step_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(dout_vld === 1'b0, "R10 step with no burst", 36'(dout_vld), 36'd0);
    end
    idle();

    // fill the array with full writes
    for (int i = 0; i < NW; i++) begin
      d = {4'($urandom()), $urandom()};
      do_write(8'(i), d, 1'b0, 1'b1, 4'hF, i[0]);
    end

    do_read(8'h10, 1'b0, "R1 controller strobe");
    do_read(8'h11, 1'b1, "R1 processor strobe");

    // R2: full write overrides byte controls
    do_write(8'h20, 36'h9_1234_5678, 1'b0, 1'b0, 4'b1010, 1'b0);
    do_read(8'h20, 1'b0, "R2 full write");

    // R3: byte write lanes 1 and 2 only
    do_write(8'h20, 36'h0_ABCD_EF01, 1'b1, 1'b0, 4'b1001, 1'b0);
    do_read(8'h20, 1'b1, "R3 byte write lanes 1,2");
    // R3: both write qualifiers high is a read, nothing written
    do_write(8'h20, 36'hF_FFFF_FFFF, 1'b1, 1'b1, 4'h0, 1'b0);
    do_read(8'h20, 1'b0, "R3 no qualifier");

    // R4: read right after write of same address
    @(negedge clk);
    idle(); addr = 8'h21; start_c_n = 1'b0; wr_all_n = 1'b0;
    @(negedge clk);
    idle(); din = 36'h5_A5A5_A5A5; addr = 8'h21; start_p_n = 1'b0;
    @(negedge clk);
    idle(); ref_mem[8'h21] = 36'h5_A5A5_A5A5;
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === 36'h5_A5A5_A5A5, "R4 read after write",
        dout, 36'h5_A5A5_A5A5);

    // R6: linear burst from low bits 2
    @(negedge clk);
    idle(); addr = 8'h4E; start_p_n = 1'b0;
    @(negedge clk);
    idle(); step_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === ref_mem[8'h4E], "R6 burst word 0", dout, ref_mem[8'h4E]);
    @(negedge clk);
    step_n = 1'b1;
    chk(dout_vld === 1'b1 && dout === ref_mem[8'h4F], "R6 burst word 1", dout, ref_mem[8'h4F]);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === ref_mem[8'h4C], "R6 burst word 2 wrap", dout, ref_mem[8'h4C]);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === ref_mem[8'h4D], "R6 burst word 3", dout, ref_mem[8'h4D]);
    // R7: output enable acts without a clock edge
    out_en_n = 1'b1;
    #2;
    chk(dout_vld === 1'b0, "R7 output enable off", 36'(dout_vld), 36'd0);
    out_en_n = 1'b0;
    #2;
    chk(dout_vld === 1'b1, "R7 output enable on", 36'(dout_vld), 36'd1);
    @(negedge clk);
    chk(dout_vld === 1'b0, "R6 burst ends", 36'(dout_vld), 36'd0);

    // R5: gated processor strobe is ignored, burst continues from 0x4E
    @(negedge clk);
    idle(); addr = 8'h90; start_p_n = 1'b0; sel1_n = 1'b1;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dout_vld === 1'b0, "R5 ignored strobe no data", 36'(dout_vld), 36'd0);
    @(negedge clk);
    chk(dout_vld === 1'b0, "R5 ignored strobe no data", 36'(dout_vld), 36'd0);
    step_n = 1'b0;
    @(negedge clk);
    step_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === ref_mem[8'h4E], "R5 counter not reloaded",
        dout, ref_mem[8'h4E]);

    // R8: start while not selected returns nothing
    @(negedge clk);
    idle(); addr = 8'h30; start_c_n = 1'b0; sel2 = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld === 1'b0, "R8 unselected start", 36'(dout_vld), 36'd0);
    // R8: deselect one edge after a read drops it
    @(negedge clk);
    idle(); addr = 8'h31; start_c_n = 1'b0;
    @(negedge clk);
    idle(); start_c_n = 1'b0; sel3_n = 1'b1;
    @(negedge clk);
    idle();
    chk(dout_vld === 1'b0, "R8 released one cycle after deselect", 36'(dout_vld), 36'd0);
    @(negedge clk);
    chk(dout_vld === 1'b0, "R8 released one cycle after deselect", 36'(dout_vld), 36'd0);
    do_read(8'h31, 1'b0, "R8 selected again");

    // R9: sleep masks output at once, ignores accesses, keeps contents
    old = ref_mem[8'h33];
    @(negedge clk);
    idle(); addr = 8'h33; start_c_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
    sleep = 1'b1;
    #2;
    chk(dout_vld === 1'b0, "R9 sleep masks output", 36'(dout_vld), 36'd0);
    @(negedge clk);
    addr = 8'h33; start_c_n = 1'b0; wr_all_n = 1'b0;
    @(negedge clk);
    idle(); din = ~old;
    @(negedge clk);
    addr = 8'h33; start_p_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld === 1'b0, "R9 access ignored in sleep", 36'(dout_vld), 36'd0);
    sleep = 1'b0;
    addr = 8'h33; start_c_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld === 1'b1 && dout === old, "R9 contents kept, resume", dout, old);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] a;
      op = $urandom_range(0, 3);
      a = 8'($urandom());
      d = {4'($urandom()), $urandom()};
      case (op)
        0: do_write(a, d, 1'b0, 1'($urandom()), 4'($urandom()), 1'($urandom()));
        1: do_write(a, d, 1'b1, 1'b0, 4'($urandom()), 1'($urandom()));
        default: do_read(a, 1'($urandom()), "R1 R2 R3 random");
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule